// File: doc/BRIEF.md
# HDB3 Line Code Encoder

This block turns a serial NRZ bit stream at 2.048 Mbit/s into the HDB3 pseudo-ternary line code. Two unipolar outputs carry the result: one pulses for marks of positive polarity and the other for marks of negative polarity. Each output is return-to-zero. It can be high only while the clock is high, and both are low while the clock is low. Binary ones become marks of alternating polarity. A run of four zeros is replaced by `000V` or `B00V`, so the line never carries more than three empty slots in a row. The violations that result alternate in polarity, so the code adds no DC.

The input is sampled on each falling clock edge into a four-slot window, which gives the encoder its lookahead. When a fourth zero arrives behind three plain zeros, the window tags the newest slot as a violation and the oldest slot of the run as a possible bipolar mark. A polarity state machine reads the oldest slot of the window. It has four states, one for each pair of last-mark and last-violation polarities:

- `ST_MNEG_VNEG`
- `ST_MNEG_VPOS`
- `ST_MPOS_VNEG`
- `ST_MPOS_VPOS`

The machine moves on four events:

- A data mark flips the mark polarity.
- A run head with equal polarities becomes a B mark, which also flips the mark polarity.
- A run head with unequal polarities stays empty and the state holds.
- A violation copies the mark polarity into the violation polarity.

The machine registers one flag for each polarity. A gate ANDs these flags with the clock to form the RZ pulses. A bit sampled at a falling edge appears on the line in the high half-period that begins 4.5 clock periods later.

Top module: `hdb3_encoder`

## Requirements
- R1: A data one is sent as a mark whose polarity is opposite to the previous mark. The first mark after reset is positive.
- R2: Once the first mark after reset has been sent, no more than three consecutive line slots are empty.
- R3: The fourth zero of a run is sent as a violation with the same polarity as the mark before it. When the last mark and the last violation differ in polarity, the first three zeros stay empty (`000V`).
- R4: When the last mark and the last violation have the same polarity, the first zero of the run is sent as a normal alternating mark B (`B00V`), and the violation takes the polarity of B.
- R5: Successive violations alternate in polarity. The first violation after reset is positive.
- R6: A bit on `nrz_in` is sampled at a falling edge of `clk`. Its line slot is the high half-period starting 4.5 clock periods later.
- R7: `pulse_pos` and `pulse_neg` are low whenever `clk` is low. During the high half they equal the registered per-slot polarity flags.
- R8: `pulse_pos` and `pulse_neg` are never high together.
- R9: Reset (`rst_n` low) forces both outputs low and sets both polarities to negative. Reset also fills the window with four empty slots; the newest three of them count as zeros toward a following run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock at 2.048 MHz; the input is sampled on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nrz_in | input | 1 | Serial NRZ data to encode |
| pulse_pos | output | 1 | RZ pulse for a positive-polarity mark |
| pulse_neg | output | 1 | RZ pulse for a negative-polarity mark |

## Verification
The bench compares every line slot against a sequential HDB3 model that starts from the reset fill. It covers several stimulus patterns:

- Runs separated by an odd number of ones: a design that inserted B in the wrong case shows the wrong violation polarity.
- Runs separated by an even number of ones: a missing B would leave two violations of the same polarity.
- A long all-zero stretch: a window that let substituted zeros start a new run would leave four empty slots or place violations early.
- A lone one: a half-cycle or whole-cycle latency error moves the pulse out of its expected slot.

Each low half-period is also checked for an output that stays high, which catches a broken RZ gate.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;

    // Tag carried by each slot of the lookahead window
    typedef enum logic [1:0] {
        SLOT_SPACE = 2'd0,   // plain zero
        SLOT_MARK  = 2'd1,   // data one
        SLOT_HEAD  = 2'd2,   // first zero of a substituted run, may become B
        SLOT_VIOL  = 2'd3    // fourth zero of a run, becomes V
    } slot_t;

    // Bit 1: polarity of last mark, bit 0: polarity of last violation (1 = positive)
    typedef enum logic [1:0] {
        ST_MNEG_VNEG = 2'b00,
        ST_MNEG_VPOS = 2'b01,
        ST_MPOS_VNEG = 2'b10,
        ST_MPOS_VPOS = 2'b11
    } pol_state_t;

endpackage

// File: rtl/hdb3_window.sv
module hdb3_window
    import hdb3_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  nrz_bit,
    output slot_t oldest
);

    localparam int LAST = RUN_LEN - 1;

    slot_t stg [RUN_LEN];
    logic  run_full;

    // A zero arriving behind LAST untagged zeros completes a run
    always_comb begin
        run_full = !nrz_bit;
        for (int i = 0; i < LAST; i++) begin
            if (stg[i] != SLOT_SPACE) begin
                run_full = 1'b0;
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RUN_LEN; i++) begin
                stg[i] <= SLOT_SPACE;
            end
        end else begin
            for (int i = 1; i < RUN_LEN; i++) begin
                stg[i] <= stg[i-1];
            end
            if (run_full) begin
                stg[LAST] <= SLOT_HEAD;
            end
            if (nrz_bit) begin
                stg[0] <= SLOT_MARK;
            end else if (run_full) begin
                stg[0] <= SLOT_VIOL;
            end else begin
                stg[0] <= SLOT_SPACE;
            end
        end
    end

    assign oldest = stg[LAST];

endmodule

// File: rtl/hdb3_polarity_fsm.sv
module hdb3_polarity_fsm
    import hdb3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t slot_in,
    output logic  flag_pos,
    output logic  flag_neg,
    output logic  flag_viol
);

    pol_state_t state_q, state_d;
    logic       mark_pos, viol_pos;
    logic       emit_pos, emit_neg, emit_viol;

    assign mark_pos = state_q[1];
    assign viol_pos = state_q[0];

    // State register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MNEG_VNEG;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MNEG_VNEG: begin
                if (slot_in == SLOT_MARK || slot_in == SLOT_HEAD) state_d = ST_MPOS_VNEG;
            end
            ST_MPOS_VNEG: begin
                if (slot_in == SLOT_MARK)      state_d = ST_MNEG_VNEG;
                else if (slot_in == SLOT_VIOL) state_d = ST_MPOS_VPOS;
            end
            ST_MPOS_VPOS: begin
                if (slot_in == SLOT_MARK || slot_in == SLOT_HEAD) state_d = ST_MNEG_VPOS;
            end
            ST_MNEG_VPOS: begin
                if (slot_in == SLOT_MARK)      state_d = ST_MPOS_VPOS;
                else if (slot_in == SLOT_VIOL) state_d = ST_MNEG_VNEG;
            end
            default: state_d = ST_MNEG_VNEG;
        endcase
    end

    // Emission decode for the slot leaving the window
    always_comb begin
        emit_pos  = 1'b0;
        emit_neg  = 1'b0;
        emit_viol = 1'b0;
        unique case (slot_in)
            SLOT_SPACE: ;
            SLOT_MARK: begin
                emit_pos = !mark_pos;
                emit_neg = mark_pos;
            end
            SLOT_HEAD: begin
                if (mark_pos == viol_pos) begin
                    emit_pos = !mark_pos;
                    emit_neg = mark_pos;
                end
            end
            SLOT_VIOL: begin
                emit_pos  = mark_pos;
                emit_neg  = !mark_pos;
                emit_viol = 1'b1;
            end
            default: ;
        endcase
    end

    // Output register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_pos  <= 1'b0;
            flag_neg  <= 1'b0;
            flag_viol <= 1'b0;
        end else begin
            flag_pos  <= emit_pos;
            flag_neg  <= emit_neg;
            flag_viol <= emit_viol;
        end
    end

endmodule

// File: rtl/hdb3_rz_gate.sv
module hdb3_rz_gate #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic [LANES-1:0] level,
    output logic [LANES-1:0] pulse
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pulse[g] = level[g] & clk;
    end

endmodule

// File: rtl/hdb3_encoder.sv
module hdb3_encoder
    import hdb3_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_in,
    output logic pulse_pos,
    output logic pulse_neg
);

    slot_t      head_slot;
    logic       flag_pos, flag_neg, flag_viol;
    logic [1:0] rz_out;

    hdb3_window #(.RUN_LEN(RUN_LEN)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .nrz_bit (nrz_in),
        .oldest  (head_slot)
    );

    hdb3_polarity_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_in   (head_slot),
        .flag_pos  (flag_pos),
        .flag_neg  (flag_neg),
        .flag_viol (flag_viol)
    );

    hdb3_rz_gate #(.LANES(2)) u_gate (
        .clk   (clk),
        .level ({flag_neg, flag_pos}),
        .pulse (rz_out)
    );

    assign pulse_pos = rz_out[0];
    assign pulse_neg = rz_out[1];

endmodule

// File: rtl/hdb3_encoder_chk.sv
module hdb3_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic flag_pos,
    input logic flag_neg,
    input logic flag_viol,
    input logic pulse_pos,
    input logic pulse_neg
);

    logic       chk_mark;   // 1 = last mark positive
    logic       chk_viol;   // 1 = last violation positive
    logic       chk_seen;
    logic [2:0] chk_gap;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_mark <= 1'b0;
            chk_viol <= 1'b0;
            chk_seen <= 1'b0;
            chk_gap  <= 3'd0;
        end else if (flag_pos || flag_neg) begin
            chk_mark <= flag_pos;
            if (flag_viol) chk_viol <= flag_pos;
            chk_seen <= 1'b1;
            chk_gap  <= 3'd0;
        end else if (chk_gap != 3'd7) begin
            chk_gap <= chk_gap + 3'd1;
        end
    end

    // R8
    excl_flags_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !(flag_pos && flag_neg));

    // R1
    ami_alt_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ((flag_pos || flag_neg) && !flag_viol) |-> (flag_pos != chk_mark));

    // R3
    viol_same_chk: assert property (@(negedge clk) disable iff (!rst_n)
        flag_viol |-> (flag_pos == chk_mark) && (flag_pos || flag_neg));

    // R5
    viol_alt_chk: assert property (@(negedge clk) disable iff (!rst_n)
        flag_viol |-> (flag_pos != chk_viol));

    // R2
    zero_gap_chk: assert property (@(negedge clk) disable iff (!rst_n)
        chk_seen |-> (chk_gap <= 3'd3));

    // R7
    rz_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_pos && !pulse_neg);

    // R7
    rz_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (pulse_pos == flag_pos) && (pulse_neg == flag_neg));

endmodule

bind hdb3_encoder hdb3_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_pos  (flag_pos),
    .flag_neg  (flag_neg),
    .flag_viol (flag_viol),
    .pulse_pos (pulse_pos),
    .pulse_neg (pulse_neg)
);

// File: tb/test_hdb3_encoder.sv
`timescale 1ns/1ps
module test_hdb3_encoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nrz_in = 1'b0;
    logic pulse_pos, pulse_neg;
    int   checks = 0;
    int   errors = 0;
    logic exp_p [68];
    logic exp_n [68];

    always #2.5 clk = ~clk;

    hdb3_encoder i_hdb3_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .nrz_in    (nrz_in),
        .pulse_pos (pulse_pos),
        .pulse_neg (pulse_neg)
    );

    task automatic check2(input string req, input string what,
                          input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual pos/neg=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Reference model: slot m carries stream element m; elements 0..3 are reset fill
    task automatic build_model(input logic [63:0] bits, input int n);
        logic s [68];
        logic mark, viol, pol;
        int   zc;
        for (int i = 0; i < 68; i++) begin
            s[i] = (i >= 4 && (i - 4) < n) ? bits[i-4] : 1'b0;
            exp_p[i] = 1'b0;
            exp_n[i] = 1'b0;
        end
        mark = 1'b0; viol = 1'b0; zc = 0;
        for (int j = 1; j < n + 4; j++) begin
            if (s[j]) begin
                pol = !mark;
                exp_p[j] = pol; exp_n[j] = !pol;
                mark = pol; zc = 0;
            end else begin
                zc++;
                if (zc == 4) begin
                    if (mark == viol) begin
                        pol = !mark;
                        exp_p[j-3] = pol; exp_n[j-3] = !pol;
                        mark = pol;
                    end
                    exp_p[j] = mark; exp_n[j] = !mark;
                    viol = mark; zc = 0;
                end
            end
        end
    endtask

    task automatic do_reset;
        rst_n  = 1'b0;
        nrz_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check2("R9", "outputs in reset", {pulse_pos, pulse_neg}, 2'b00);
        rst_n = 1'b1;
    endtask

    task automatic run_stream(input logic [63:0] bits, input int n, input string req);
        int gap;
        bit seen;
        do_reset();
        build_model(bits, n);
        gap = 0; seen = 0;
        for (int m = 0; m < n; m++) begin
            nrz_in = bits[m];
            @(negedge clk); #1;
            check2("R7", $sformatf("low half slot %0d", m), {pulse_pos, pulse_neg}, 2'b00);
            @(posedge clk); #1;
            check2(req, $sformatf("slot %0d", m), {pulse_pos, pulse_neg}, {exp_p[m], exp_n[m]});
            checks++;
            if (pulse_pos && pulse_neg) begin
                errors++;
                $display("FAIL R8 slot %0d: actual both high expected exclusive", m);
            end
            if (pulse_pos || pulse_neg) begin
                seen = 1; gap = 0;
            end else if (seen) begin
                gap++;
            end
            checks++;
            if (gap > 3) begin
                errors++;
                $display("FAIL R2 slot %0d: actual empty run=%0d expected<=3", m, gap);
            end
        end
        nrz_in = 1'b0;
    endtask

    // R9, R4: all zeros straight after reset, fill joins the first run
    task automatic t_after_reset;
        run_stream(64'h0, 16, "R9,R4");
    endtask

    // R1: continuous ones alternate
    task automatic t_alternating_ones;
        run_stream(64'hFFFFF, 20, "R1");
    endtask

    // R3: one mark between runs gives 000V
    task automatic t_odd_gap;
        run_stream(64'h0421, 16, "R3");
    endtask

    // R4, R5: two marks between runs gives B00V, violations alternate
    task automatic t_even_gap;
        run_stream(64'h30C3, 18, "R4,R5");
    endtask

    // R2, R5: long zero stretch
    task automatic t_long_run;
        run_stream(64'h1, 40, "R2,R5");
    endtask

    // R6: lone one lands 4.5 periods later (slot 9)
    task automatic t_latency;
        run_stream(64'h20, 14, "R6");
    endtask

    // R1, R3, R4: mixed pattern
    task automatic t_mixed;
        run_stream(64'h3A05_0081_C460_0B21, 64, "R1,R3,R4");
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_after_reset();
        t_alternating_ones();
        t_odd_gap();
        t_even_gap();
        t_long_run();
        t_latency();
        t_mixed();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule